// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block carries out the data operations of a small 8-bit accumulator processor. Each request supplies an operation code, a register value (the accumulator or an index register, chosen by the caller), an operand byte and the current status byte. One clock later the block presents the result byte, a strobe saying whether that result is to be written back, and the new status byte.

Supported operations are add with carry, subtract with borrow, the three bitwise operations, a bit test, compare, increment, decrement, shifts and rotates in both directions, two kinds of transfer, and direct commands that set or clear single status bits. Each operation has its own rule for which status bits it touches. One transfer touches none, for moves into the stack pointer. The decimal bit is stored and can be changed, but it never changes the arithmetic. Register storage, memory access and instruction sequencing belong to the surrounding core.

Top module: `acc_alu_core`

## Requirements
- R1: On a clock edge with `rst` high, the block clears `out_valid`, `res_we`, `res_out` and `flags_out` to zero.
- R2: Status byte layout: N=bit 7, V=bit 6, D=bit 3, I=bit 2, Z=bit 1, C=bit 0. Outputs appear on the edge after the one that samples `op_valid`, and `out_valid` follows `op_valid` with that delay. While `op_valid` is low, `res_we` is 0 and `res_out` and `flags_out` hold their values.
- R3: Add (code 0) writes A+M+C modulo 256. C is set on unsigned carry out of bit 7. V is set when A and M have the same sign and the result's sign differs. N and Z come from the result.
- R4: Subtract (code 1) writes A-M-(1-C). C is set when no borrow occurs. V reports signed overflow, and N and Z come from the result. Examples: with C=1, 0x00-0x01 gives 0xFF with N=1 and V=0, 0x80-0x01 gives 0x7F with V=1 and N=0, 0x7F-0xFF gives 0x80 with N=1 and V=1, and 0x00-0x80 gives 0x80 with N=1 and V=1. With C=0, 0xC0-0x40 gives 0x7F with V=1, and 0x00-0x7F gives 0x80.
- R5: AND (code 2), XOR (code 3) and OR (code 4) write the bitwise result and set N and Z from it. V and C are unchanged.
- R6: Bit test (code 5) does not write. Z is set when A AND M is zero. N copies M bit 7 and V copies M bit 6.
- R7: Compare (code 6) does not write. It sets C when A>=M as unsigned values, Z when A==M, and N from bit 7 of A-M.
- R8: Increment (code 7) and decrement (code 8) act on M, wrap modulo 256, and set only N and Z.
- R9: Shift left (9) and shift right (10) fill with zero. Rotate left (11) and rotate right (12) fill with the old C. The bit shifted out goes to C, N and Z come from the result, and V is unchanged.
- R10: Move (code 13) writes M and sets N and Z from it. Quiet move (code 14) writes M and leaves every status bit unchanged.
- R11: Flag commands write nothing and change one bit: 15 sets C, 16 clears C, 17 sets D, 18 clears D, 19 sets I, 20 clears I, 21 clears V. Status bits 5 and 4 are always copied from the input.
- R12: The D bit has no effect on the result or on the flags that add and subtract produce.
- R13: Codes 22 to 31 write nothing and leave the status byte equal to the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 5 | Operation code |
| acc_in | input | 8 | Register operand A |
| opnd_in | input | 8 | Operand byte M |
| flags_in | input | 8 | Current status byte |
| res_out | output | 8 | Result byte (registered) |
| res_we | output | 1 | Result write-back enable |
| out_valid | output | 1 | Result and status valid |
| flags_out | output | 8 | New status byte |

## Verification
The assertions check the timing rules on every cycle. They cover write enable only with valid output, valid following the request by one cycle, and no write from bit test or compare. They also check that a quiet move and an undefined code leave the status byte untouched, that Z agrees with the written result, and that the spare status bits are copied through. Exact arithmetic needs the bench's sweeps: carry and overflow for add, subtract and compare over every A value against a spread of operands, plus shifts, rotates and wraparound over all 256 values. The sweeps also run with D both set and clear, which shows that D has no effect.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int SW  = 8;
  localparam int OPW = 5;
  localparam int FN = 7;
  localparam int FV = 6;
  localparam int FD = 3;
  localparam int FI = 2;
  localparam int FZ = 1;
  localparam int FC = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_AND  = 5'd2,  OP_XOR  = 5'd3,
    OP_OR   = 5'd4,  OP_BIT  = 5'd5,  OP_CMP  = 5'd6,  OP_INC  = 5'd7,
    OP_DEC  = 5'd8,  OP_SHL  = 5'd9,  OP_SHR  = 5'd10, OP_ROL  = 5'd11,
    OP_ROR  = 5'd12, OP_MOV  = 5'd13, OP_MOVQ = 5'd14, OP_SETC = 5'd15,
    OP_CLRC = 5'd16, OP_SETD = 5'd17, OP_CLRD = 5'd18, OP_SETI = 5'd19,
    OP_CLRI = 5'd20, OP_CLRV = 5'd21
  } alu_op_e;

  localparam logic [OPW-1:0] OP_LAST = 5'd21;

  typedef enum logic [1:0] { LG_AND = 2'd0, LG_XOR = 2'd1, LG_OR = 2'd2 } logic_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          ovf
);
  logic [DW-1:0] b_eff;
  logic [DW:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    sum   = wide[DW-1:0];
    cout  = wide[DW];
    ovf   = (a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] d,
  input  logic          cin,
  input  logic          left,
  input  logic          rotate,
  output logic [DW-1:0] q,
  output logic          cout
);
  logic fill;

  always_comb begin
    fill = rotate & cin;
    if (left) begin
      q    = {d[DW-2:0], fill};
      cout = d[DW-1];
    end else begin
      q    = {fill, d[DW-1:1]};
      cout = d[0];
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic_sel_e    sel,
  output logic [DW-1:0] q
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign q[i] = (sel == LG_AND) ? (a[i] & b[i]) :
                  (sel == LG_XOR) ? (a[i] ^ b[i]) :
                                    (a[i] | b[i]);
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  acc_in,
  input  logic [DW-1:0]  opnd_in,
  input  logic [SW-1:0]  flags_in,
  output logic [DW-1:0]  res_out,
  output logic           res_we,
  output logic           out_valid,
  output logic [SW-1:0]  flags_out
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] as_sum, lg_q, sh_q, nres;
  logic          as_cout, as_ovf, as_cin, as_sub, sh_cout, sh_left, sh_rot;
  logic          nwe, setnz;
  logic_sel_e    lg_sel;
  logic [SW-1:0] nfl;

  // Operand steering for the shared units
  always_comb begin
    as_sub  = (op_code == OP_SUB) || (op_code == OP_CMP);
    as_cin  = (op_code == OP_CMP) ? 1'b1 : flags_in[FC];
    sh_left = (op_code == OP_SHL) || (op_code == OP_ROL);
    sh_rot  = (op_code == OP_ROL) || (op_code == OP_ROR);
    case (op_code)
      OP_XOR:  lg_sel = LG_XOR;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu_addsub #(.DW(DW)) u_addsub (
    .a(acc_in), .b(opnd_in), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  alu_logic #(.DW(DW)) u_logic (
    .a(acc_in), .b(opnd_in), .sel(lg_sel), .q(lg_q)
  );

  alu_shift #(.DW(DW)) u_shift (
    .d(opnd_in), .cin(flags_in[FC]), .left(sh_left), .rotate(sh_rot),
    .q(sh_q), .cout(sh_cout)
  );

  // Result selection and per-operation flag rules
  always_comb begin
    nres  = opnd_in;
    nwe   = 1'b0;
    setnz = 1'b0;
    nfl   = flags_in;
    case (op_code)
      OP_ADD, OP_SUB: begin
        nres = as_sum; nwe = 1'b1; setnz = 1'b1;
        nfl[FC] = as_cout; nfl[FV] = as_ovf;
      end
      OP_AND, OP_XOR, OP_OR: begin
        nres = lg_q; nwe = 1'b1; setnz = 1'b1;
      end
      OP_BIT: begin
        nres = lg_q;
        nfl[FZ] = (lg_q == '0);
        nfl[FN] = opnd_in[DW-1];
        nfl[FV] = opnd_in[DW-2];
      end
      OP_CMP: begin
        nres = as_sum; setnz = 1'b1; nfl[FC] = as_cout;
      end
      OP_INC: begin nres = opnd_in + ONE; nwe = 1'b1; setnz = 1'b1; end
      OP_DEC: begin nres = opnd_in - ONE; nwe = 1'b1; setnz = 1'b1; end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        nres = sh_q; nwe = 1'b1; setnz = 1'b1; nfl[FC] = sh_cout;
      end
      OP_MOV:  begin nwe = 1'b1; setnz = 1'b1; end
      OP_MOVQ: nwe = 1'b1;
      OP_SETC: nfl[FC] = 1'b1;
      OP_CLRC: nfl[FC] = 1'b0;
      OP_SETD: nfl[FD] = 1'b1;
      OP_CLRD: nfl[FD] = 1'b0;
      OP_SETI: nfl[FI] = 1'b1;
      OP_CLRI: nfl[FI] = 1'b0;
      OP_CLRV: nfl[FV] = 1'b0;
      default: ;
    endcase
    if (setnz) begin
      nfl[FN] = nres[DW-1];
      nfl[FZ] = (nres == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      res_we    <= 1'b0;
      out_valid <= 1'b0;
      flags_out <= '0;
    end else begin
      out_valid <= op_valid;
      res_we    <= op_valid & nwe;
      if (op_valid) begin
        res_out   <= nres;
        flags_out <= nfl;
      end
    end
  end
endmodule

// File: rtl/acc_alu_core_chk.sv
module acc_alu_core_chk
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           op_valid,
  input logic [OPW-1:0] op_code,
  input logic [DW-1:0]  acc_in,
  input logic [DW-1:0]  opnd_in,
  input logic [SW-1:0]  flags_in,
  input logic [DW-1:0]  res_out,
  input logic           res_we,
  input logic           out_valid,
  input logic [SW-1:0]  flags_out
);
  p_we_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    res_we |-> out_valid);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(op_valid)));

  p_bit_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_BIT) |=>
      (!res_we && flags_out[FV] == $past(opnd_in[DW-2])
       && flags_out[FZ] == (($past(acc_in) & $past(opnd_in)) == '0)));

  p_cmp_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CMP) |=> !res_we);

  p_quiet_move_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_MOVQ) |=>
      (res_we && flags_out == $past(flags_in) && res_out == $past(opnd_in)));

  // Z agrees with the written result for every N/Z-updating write (R5 and others)
  p_zero_tracks_result_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code <= OP_MOV && op_code != OP_BIT && op_code != OP_CMP) |=>
      (flags_out[FZ] == (res_out == '0)));

  p_spare_bits_r11: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (flags_out[5:4] == $past(flags_in[5:4])));

  p_undefined_code_r13: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > OP_LAST) |=> (!res_we && flags_out == $past(flags_in)));
endmodule

bind acc_alu_core acc_alu_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
  .res_out(res_out), .res_we(res_we), .out_valid(out_valid),
  .flags_out(flags_out)
);

// File: tb/acc_alu_core_bench.sv
`timescale 1ns/1ps
module acc_alu_core_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] acc_in = '0, opnd_in = '0, flags_in = '0;
  logic [7:0] res_out, flags_out;
  logic       res_we, out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_alu_core u_acc_alu_core (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
    .res_out(res_out), .res_we(res_we), .out_valid(out_valid),
    .flags_out(flags_out)
  );

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // Expected behaviour from the requirements, in integer arithmetic
  task automatic model(input int op, input int a, input int m, input int f,
                       output int r, output int w, output int fo);
    int c, s, sv;
    bit nz;
    c = f & 1; fo = f; w = 0; r = m; nz = 0;
    case (op)
      0: begin s = a + m + c; sv = sgn(a) + sgn(m) + c;
               r = s & 255; w = 1; nz = 1;
               fo = (fo & ~8'h41) | ((s > 255) ? 1 : 0) | ((sv > 127 || sv < -128) ? 8'h40 : 0); end
      1: begin s = a - m - (1 - c); sv = sgn(a) - sgn(m) - (1 - c);
               r = s & 255; w = 1; nz = 1;
               fo = (fo & ~8'h41) | ((s >= 0) ? 1 : 0) | ((sv > 127 || sv < -128) ? 8'h40 : 0); end
      2: begin r = a & m; w = 1; nz = 1; end
      3: begin r = a ^ m; w = 1; nz = 1; end
      4: begin r = a | m; w = 1; nz = 1; end
      5: fo = (fo & ~8'hC2) | (m & 8'hC0) | (((a & m) == 0) ? 2 : 0);
      6: begin r = (a - m) & 255; nz = 1; fo = (fo & ~1) | ((a >= m) ? 1 : 0); end
      7: begin r = (m + 1) % 256; w = 1; nz = 1; end
      8: begin r = (m + 255) % 256; w = 1; nz = 1; end
      9: begin r = (m * 2) % 256; w = 1; nz = 1; fo = (fo & ~1) | (m >> 7); end
      10: begin r = m / 2; w = 1; nz = 1; fo = (fo & ~1) | (m & 1); end
      11: begin r = (m * 2 + c) % 256; w = 1; nz = 1; fo = (fo & ~1) | (m >> 7); end
      12: begin r = m / 2 + c * 128; w = 1; nz = 1; fo = (fo & ~1) | (m & 1); end
      13: begin w = 1; nz = 1; end
      14: w = 1;
      15: fo = fo | 1;
      16: fo = fo & ~1;
      17: fo = fo | 8;
      18: fo = fo & ~8;
      19: fo = fo | 4;
      20: fo = fo & ~4;
      21: fo = fo & ~8'h40;
      default: ;
    endcase
    if (nz) begin
      fo = (fo & ~8'h82) | (r & 8'h80) | ((r == 0) ? 2 : 0);
    end
  endtask

  // Drive one request, then sample one cycle later away from the edge
  task automatic run(input string tag, input int op, input int a, input int m, input int f);
    int r, w, fo;
    model(op, a, m, f, r, w, fo);
    @(negedge clk);
    op_valid = 1'b1; op_code = op[4:0];
    acc_in = a[7:0]; opnd_in = m[7:0]; flags_in = f[7:0];
    @(negedge clk);
    checks++;
    if (!out_valid || int'(res_we) != w || int'(flags_out) != fo || (w == 1 && int'(res_out) != r)) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h m=%02h f=%02h: got res=%02h we=%0b fl=%02h vld=%0b, expected res=%02h we=%0d fl=%02h",
               tag, op, a, m, f, res_out, res_we, flags_out, out_valid, r, w, fo);
    end
  endtask

  function automatic int opnd_pick(input int j);
    case (j)
      16: return 8'h01;
      17: return 8'h7F;
      18: return 8'h80;
      19: return 8'h40;
      default: return (j == 20) ? 8'hFE : j * 17;
    endcase
  endfunction

  function automatic int fmix(input int a, input int m, input int c);
    return ((a ^ (m << 1) ^ 8'h96) & 8'hFE) | c;
  endfunction

  // Watchdog: counts as a failed check and still prints the summary
  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held_r, held_f;
    op_valid = 1'b1; op_code = 5'd0; acc_in = 8'hFF; opnd_in = 8'hFF; flags_in = 8'hFF;
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (out_valid || res_we || res_out != 0 || flags_out != 0) begin
      errors++;
      $display("FAIL R1: got vld=%0b we=%0b res=%02h fl=%02h, expected all zero",
               out_valid, res_we, res_out, flags_out);
    end
    op_valid = 1'b0;
    rst = 1'b0;

    // R4 named corner cases
    run("R4 0-1", 1, 8'h00, 8'h01, 8'h01);
    run("R4 80-1", 1, 8'h80, 8'h01, 8'h01);
    run("R4 7F-FF", 1, 8'h7F, 8'hFF, 8'h01);
    run("R4 C0-40", 1, 8'hC0, 8'h40, 8'h00);
    run("R4 0-80", 1, 8'h00, 8'h80, 8'h01);
    run("R4 0-7F", 1, 8'h00, 8'h7F, 8'h00);

    // R2 hold: op_valid low with new inputs leaves outputs alone
    held_r = res_out; held_f = flags_out;
    @(negedge clk);
    op_valid = 1'b0; op_code = 5'd13; opnd_in = 8'h00; flags_in = 8'hAA;
    @(negedge clk);
    checks++;
    if (out_valid || res_we || res_out != held_r || flags_out != held_f) begin
      errors++;
      $display("FAIL R2: got vld=%0b we=%0b res=%02h fl=%02h, expected 0 0 %02h %02h",
               out_valid, res_we, res_out, flags_out, held_r, held_f);
    end

    // R3, R4, R12: add/subtract sweep, D bit varies with the operands
    for (int a = 0; a < 256; a++)
      for (int j = 0; j < 21; j++)
        for (int c = 0; c < 2; c++) begin
          run("R3 add", 0, a, opnd_pick(j), fmix(a, opnd_pick(j), c));
          run("R4 sub", 1, a, opnd_pick(j), fmix(a, opnd_pick(j), c));
        end
    // R12: same add with D set and clear
    run("R12 add D=1", 0, 8'h19, 8'h28, 8'h08);
    run("R12 add D=0", 0, 8'h19, 8'h28, 8'h00);
    run("R12 sub D=1", 1, 8'h10, 8'h01, 8'h09);

    // R5, R6, R7 sweeps
    for (int a = 0; a < 256; a++)
      for (int j = 0; j < 21; j++) begin
        run("R5 and", 2, a, opnd_pick(j), fmix(a, opnd_pick(j), a & 1));
        run("R5 xor", 3, a, opnd_pick(j), fmix(a, opnd_pick(j), 0));
        run("R5 or",  4, a, opnd_pick(j), fmix(a, opnd_pick(j), 1));
        run("R6 bit", 5, a, opnd_pick(j), fmix(a, opnd_pick(j), j & 1));
        run("R7 cmp", 6, a, opnd_pick(j), fmix(a, opnd_pick(j), a & 1));
      end

    // R8, R9, R10 over every operand value, both carry inputs
    for (int m = 0; m < 256; m++)
      for (int c = 0; c < 2; c++) begin
        run("R8 inc", 7, 8'h5A, m, fmix(m, m, c));
        run("R8 dec", 8, 8'h5A, m, fmix(m, 3, c));
        run("R9 shl", 9, 8'h00, m, fmix(m, 5, c));
        run("R9 shr", 10, 8'h00, m, fmix(m, 7, c) | 8'h40);
        run("R9 rol", 11, 8'h00, m, fmix(m, 9, c));
        run("R9 ror", 12, 8'h00, m, fmix(m, 11, c));
        run("R10 mov", 13, 8'h00, m, fmix(m, 13, c));
        run("R10 movq", 14, 8'h00, m, fmix(m, 15, c));
      end

    // R11 flag commands, R13 undefined codes
    for (int op = 15; op < 22; op++) begin
      run("R11 flag", op, 8'h33, 8'h44, 8'h00);
      run("R11 flag", op, 8'h33, 8'h44, 8'hFF);
      run("R11 flag", op, 8'h33, 8'h44, 8'h5A);
    end
    for (int op = 22; op < 32; op++) begin
      run("R13 undef", op, 8'h12, 8'h34, 8'hC3);
      run("R13 undef", op, 8'h00, 8'h00, 8'h3C);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule